// File: doc/BRIEF.md
# Logical-Page Counter-Mode Pad Engine

This block produces the one-time pads that encrypt and decrypt cache lines in counter-mode memory encryption. The seed for each pad does not contain the line's address. Its spatial part is a logical page number. A frame receives this number from a global page counter that only counts upward, at the moment the page is first placed in that frame. Its temporal part is a per-line write counter, which steps on every writeback. Because the address takes no part in the seed, shared pages, remapped frames and swapped pages never have to be re-encrypted.

A single request port accepts three kinds of request. A frame load stamps a frame with a fresh page number and clears the line counters of that frame. A writeback steps the line counter and then encrypts the supplied line. A fill decrypts the supplied line under the counter value it currently holds. The pad comes from a keyed add/rotate/XOR permutation split over two register stages. It depends only on the seed and the key, so a fill can be issued while the memory read is still in flight. The key must stay stable while requests are in flight. Each line is cut into 128-bit chunks, and each chunk has its own permutation lane whose input carries the chunk index as a tweak.

Top module: `lpc_crypt_top`

## Requirements
- R1: After reset, rsp_valid_o and sat_err_o are 0, every frame holds page number 0 (the value meaning "never loaded"), every line counter is 0, and the global counter holds 1.
- R2: An accepted frame load (req_op_i = 2'b00) gives the frame the current global counter value and then increments the global counter by one.
- R3: A writeback (req_op_i = 2'b01) increments the addressed line's counter, and the seed for that writeback uses the incremented value.
- R4: The seed on rsp_seed_o is {line counter (upper BCTR_W bits), page number (lower GPC_W bits)} and holds no frame or line index bits.
- R5: A fill (req_op_i = 2'b10) uses the line's current counter and leaves it unchanged.
- R6: rsp_data_o equals req_data_i XOR pad(seed), so a fill given a writeback's ciphertext under the same seed returns the plaintext, and a fill of all-zero data returns the pad itself.
- R7: A writeback or fill accepted at clock edge N produces rsp_valid_o = 1 after edge N+1 only. A load produces no response.
- R8: Reloading a frame gives it a new page number and clears all of its line counters to 0.
- R9: When the global counter reaches all ones, sat_err_o goes to 1 and stays there, and any further load is refused: the frame table and the global counter do not change.
- R10: Two writebacks of the same plaintext to the same line produce different ciphertexts.
- R11: Request code 2'b11 is ignored. It produces no response and changes no counter.
- R12: A fill issued in the cycle right after a writeback to the same line uses the counter value written by that writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_i | input | 128 | Cipher key, held stable while requests are in flight |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 00 load, 01 writeback, 10 fill, 11 ignored |
| req_frame_i | input | $clog2(FRAMES) | Frame index |
| req_line_i | input | $clog2(LINES) | Line index inside the frame |
| req_data_i | input | LINE_W | Plaintext (writeback) or ciphertext (fill) |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_data_o | output | LINE_W | Ciphertext or plaintext result |
| rsp_seed_o | output | BCTR_W+GPC_W | Seed used for this response |
| sat_err_o | output | 1 | Global page counter exhausted |

## Verification
With a 64-bit global counter, saturation can never be reached through the ports, so the bench builds the block with a 4-bit counter and issues loads until every page number is used. It then confirms that a further load leaves the table untouched. The other hard case is a fill that arrives in the cycle right after a writeback to the same line, before the writeback's response has come out. The bench drives the two requests on consecutive cycles and checks that the XOR of the two responses recovers the plaintext.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

   typedef enum logic [1:0] {
      OP_LOAD = 2'b00,
      OP_WB   = 2'b01,
      OP_FILL = 2'b10,
      OP_RSVD = 2'b11
   } lpc_op_e;

   localparam int BLK_W = 128;

   function automatic logic [31:0] rotl32(input logic [31:0] x, input int unsigned n);
      return (x << n) | (x >> (32 - n));
   endfunction

   function automatic logic [BLK_W-1:0] arx_round(input logic [BLK_W-1:0] s,
                                                  input logic [BLK_W-1:0] k,
                                                  input logic [7:0]       rc);
      logic [31:0] a, b, c, d;
      {d, c, b, a} = s ^ k;
      a = a + b + {24'd0, rc};
      d = rotl32(d ^ a, 16);
      c = c + d;
      b = rotl32(b ^ c, 12);
      a = a + b;
      d = rotl32(d ^ a, 8);
      c = c + d;
      b = rotl32(b ^ c, 7);
      return {c, b, a, d};
   endfunction

endpackage

// File: rtl/lpc_frame_table.sv
module lpc_frame_table #(
   parameter int FRAMES = 4,
   parameter int GPC_W  = 64,
   localparam int FRAME_W = $clog2(FRAMES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_en_i,
   input  logic [FRAME_W-1:0] load_frame_i,
   input  logic [FRAME_W-1:0] rd_frame_i,
   output logic [GPC_W-1:0]   rd_lpid_o,
   output logic [GPC_W-1:0]   gpc_o,
   output logic               sat_o
);
   logic [GPC_W-1:0] lpid_q [FRAMES];
   logic [GPC_W-1:0] gpc_q;
   logic             sat_w;

   assign sat_w = (gpc_q == '1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gpc_q <= GPC_W'(1);
         for (int i = 0; i < FRAMES; i++) lpid_q[i] <= '0;
      end else if (load_en_i && !sat_w) begin
         lpid_q[load_frame_i] <= gpc_q;
         gpc_q                <= gpc_q + GPC_W'(1);
      end
   end

   assign rd_lpid_o = lpid_q[rd_frame_i];
   assign gpc_o     = gpc_q;
   assign sat_o     = sat_w;
endmodule

// File: rtl/lpc_block_ctrs.sv
module lpc_block_ctrs #(
   parameter int FRAMES = 4,
   parameter int LINES  = 4,
   parameter int BCTR_W = 16,
   localparam int FRAME_W = $clog2(FRAMES),
   localparam int LINE_IW = $clog2(LINES),
   localparam int ENTRIES = FRAMES * LINES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_en_i,
   input  logic [FRAME_W-1:0] clr_frame_i,
   input  logic               inc_en_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic [LINE_IW-1:0] line_i,
   output logic [BCTR_W-1:0]  ctr_o
);
   logic [BCTR_W-1:0] ctr_q [ENTRIES];
   logic [FRAME_W+LINE_IW-1:0] idx_w;

   assign idx_w = {frame_i, line_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (clr_en_i && (FRAME_W'(i / LINES) == clr_frame_i))
               ctr_q[i] <= '0;
            else if (inc_en_i && ((FRAME_W+LINE_IW)'(i) == idx_w))
               ctr_q[i] <= ctr_q[i] + BCTR_W'(1);
         end
      end
   end

   assign ctr_o = ctr_q[idx_w];
endmodule

// File: rtl/lpc_pad_cipher.sv
module lpc_pad_cipher
   import lpc_pkg::*;
#(
   parameter int LINE_W = 256,
   parameter int SEED_W = 80,
   parameter int ROUNDS = 8,
   localparam int CHUNKS = LINE_W / BLK_W,
   localparam int HALF   = ROUNDS / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   input  logic [BLK_W-1:0]  key_i,
   input  logic [SEED_W-1:0] seed_i,
   input  logic [LINE_W-1:0] data_i,
   output logic              out_valid_o,
   output logic [LINE_W-1:0] out_data_o,
   output logic [SEED_W-1:0] out_seed_o
);
   logic              v1_q;
   logic [SEED_W-1:0] seed1_q;
   logic [LINE_W-1:0] data1_q;
   logic [LINE_W-1:0] pad_w;

   for (genvar c = 0; c < CHUNKS; c++) begin : g_lane
      logic [BLK_W-1:0] blk_in, mid_d, mid_q, fin_d;

      assign blk_in = BLK_W'(seed_i) | (BLK_W'(c) << SEED_W);

      always_comb begin
         mid_d = blk_in;
         for (int r = 0; r < HALF; r++) mid_d = arx_round(mid_d, key_i, 8'(r + 1));
      end

      always_ff @(posedge clk) begin
         if (!rst_n) mid_q <= '0;
         else        mid_q <= mid_d;
      end

      always_comb begin
         fin_d = mid_q;
         for (int r = HALF; r < ROUNDS; r++) fin_d = arx_round(fin_d, key_i, 8'(r + 1));
      end

      assign pad_w[c*BLK_W +: BLK_W] = fin_d ^ key_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_q        <= 1'b0;
         seed1_q     <= '0;
         data1_q     <= '0;
         out_valid_o <= 1'b0;
         out_data_o  <= '0;
         out_seed_o  <= '0;
      end else begin
         v1_q        <= in_valid_i;
         seed1_q     <= seed_i;
         data1_q     <= data_i;
         out_valid_o <= v1_q;
         out_data_o  <= data1_q ^ pad_w;
         out_seed_o  <= seed1_q;
      end
   end
endmodule

// File: rtl/lpc_crypt_top.sv
module lpc_crypt_top
   import lpc_pkg::*;
#(
   parameter int FRAMES = 4,
   parameter int LINES  = 4,
   parameter int LINE_W = 256,
   parameter int BCTR_W = 16,
   parameter int GPC_W  = 64,
   parameter int ROUNDS = 8,
   localparam int FRAME_W = $clog2(FRAMES),
   localparam int LINE_IW = $clog2(LINES),
   localparam int SEED_W  = BCTR_W + GPC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [127:0]       key_i,
   input  logic               req_valid_i,
   input  logic [1:0]         req_op_i,
   input  logic [FRAME_W-1:0] req_frame_i,
   input  logic [LINE_IW-1:0] req_line_i,
   input  logic [LINE_W-1:0]  req_data_i,
   output logic               rsp_valid_o,
   output logic [LINE_W-1:0]  rsp_data_o,
   output logic [SEED_W-1:0]  rsp_seed_o,
   output logic               sat_err_o
);
   if (FRAMES < 2 || (1 << FRAME_W) != FRAMES) begin : g_bad_frames
      $error("FRAMES must be a power of two of at least 2");
   end
   if (LINES < 2 || (1 << LINE_IW) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (LINE_W < BLK_W || (LINE_W % BLK_W) != 0) begin : g_bad_line_w
      $error("LINE_W must be a multiple of 128");
   end
   if (SEED_W + 8 > BLK_W || BCTR_W < 1 || GPC_W < 2) begin : g_bad_seed
      $error("seed fields do not fit one cipher block with the chunk tweak");
   end
   if (ROUNDS < 2 || (ROUNDS % 2) != 0) begin : g_bad_rounds
      $error("ROUNDS must be even and at least 2");
   end

   logic              is_load, is_wb, is_fill, load_ok;
   logic [GPC_W-1:0]  lpid_w;
   logic [GPC_W-1:0]  gpc_w;
   logic              sat_w;
   logic [BCTR_W-1:0] ctr_cur, ctr_sel;
   logic [SEED_W-1:0] seed_w;

   assign is_load = req_valid_i && (req_op_i == OP_LOAD);
   assign is_wb   = req_valid_i && (req_op_i == OP_WB);
   assign is_fill = req_valid_i && (req_op_i == OP_FILL);
   assign load_ok = is_load && !sat_w;

   lpc_frame_table #(.FRAMES(FRAMES), .GPC_W(GPC_W)) ftab_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_en_i    (is_load),
      .load_frame_i (req_frame_i),
      .rd_frame_i   (req_frame_i),
      .rd_lpid_o    (lpid_w),
      .gpc_o        (gpc_w),
      .sat_o        (sat_w)
   );

   lpc_block_ctrs #(.FRAMES(FRAMES), .LINES(LINES), .BCTR_W(BCTR_W)) bctr_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_en_i    (load_ok),
      .clr_frame_i (req_frame_i),
      .inc_en_i    (is_wb),
      .frame_i     (req_frame_i),
      .line_i      (req_line_i),
      .ctr_o       (ctr_cur)
   );

   assign ctr_sel = is_wb ? ctr_cur + BCTR_W'(1) : ctr_cur;
   assign seed_w  = {ctr_sel, lpid_w};

   lpc_pad_cipher #(.LINE_W(LINE_W), .SEED_W(SEED_W), .ROUNDS(ROUNDS)) ciph_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid_i  (is_wb || is_fill),
      .key_i       (key_i),
      .seed_i      (seed_w),
      .data_i      (req_data_i),
      .out_valid_o (rsp_valid_o),
      .out_data_o  (rsp_data_o),
      .out_seed_o  (rsp_seed_o)
   );

   assign sat_err_o = sat_w;
endmodule

// File: rtl/lpc_crypt_chk.sv
module lpc_crypt_chk #(
   parameter int GPC_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [1:0]       req_op,
   input logic             rsp_valid,
   input logic             sat_err,
   input logic [GPC_W-1:0] gpc
);
   logic enc_req;
   assign enc_req = req_valid && (req_op == 2'b01 || req_op == 2'b10);

   assert_enc_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      enc_req |-> ##2 rsp_valid);

   assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !enc_req |-> ##2 !rsp_valid);

   assert_load_steps_gpc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b00 && !sat_err) |=> (gpc == $past(gpc) + GPC_W'(1)));

   assert_sat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sat_err |=> sat_err);

   assert_sat_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b00 && sat_err) |=> $stable(gpc));

   assert_gpc_never_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      gpc != '0);
endmodule

bind lpc_crypt_top lpc_crypt_chk #(.GPC_W(GPC_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid_i),
   .req_op    (req_op_i),
   .rsp_valid (rsp_valid_o),
   .sat_err   (sat_err_o),
   .gpc       (gpc_w)
);

// File: tb/lpc_crypt_top_tb_top.sv
module lpc_crypt_top_tb_top;
   localparam int FRAMES = 4;
   localparam int LINES  = 4;
   localparam int LINE_W = 256;
   localparam int BCTR_W = 16;
   localparam int GPC_W  = 4;
   localparam int SEED_W = BCTR_W + GPC_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [127:0]      key = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
   logic              req_valid = 1'b0;
   logic [1:0]        req_op = 2'b00;
   logic [1:0]        req_frame = '0;
   logic [1:0]        req_line = '0;
   logic [LINE_W-1:0] req_data = '0;
   logic              rsp_valid;
   logic [LINE_W-1:0] rsp_data;
   logic [SEED_W-1:0] rsp_seed;
   logic              sat_err;

   int nchecks = 0;
   int nerrs   = 0;
   bit done    = 0;
   int next_id = 1;

   logic [LINE_W-1:0] got_d;
   logic [SEED_W-1:0] got_s;

   localparam logic [LINE_W-1:0] PLAIN = {4{64'h0123_4567_89AB_CDEF}};

   always #5 clk = ~clk;

   lpc_crypt_top #(.FRAMES(FRAMES), .LINES(LINES), .LINE_W(LINE_W),
                   .BCTR_W(BCTR_W), .GPC_W(GPC_W), .ROUNDS(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .key_i(key),
      .req_valid_i(req_valid), .req_op_i(req_op), .req_frame_i(req_frame),
      .req_line_i(req_line), .req_data_i(req_data),
      .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_seed_o(rsp_seed),
      .sat_err_o(sat_err)
   );

   task automatic check_eq(input string req, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
      nchecks++;
      if (act !== exp) begin
         nerrs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_ne(input string req, input logic [LINE_W-1:0] a, input logic [LINE_W-1:0] b);
      nchecks++;
      if (a === b) begin
         nerrs++;
         $display("FAIL %s actual=%h expected different from %h", req, a, b);
      end
   endtask

   function automatic logic [LINE_W-1:0] seed_of(input int ctr, input int lpid);
      logic [SEED_W-1:0] s;
      s = {BCTR_W'(ctr), GPC_W'(lpid)};
      return LINE_W'(s);
   endfunction

   // writeback or fill; checks the two-cycle response timing (R7)
   task automatic do_enc(input logic [1:0] op, input int f, input int l, input logic [LINE_W-1:0] d);
      logic mid_v;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_frame = 2'(f); req_line = 2'(l); req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      mid_v = rsp_valid;
      @(negedge clk);
      check_eq("R7 no response one cycle after request", LINE_W'(mid_v), '0);
      check_eq("R7 response two cycles after request", LINE_W'(rsp_valid), 1);
      got_d = rsp_data;
      got_s = rsp_seed;
   endtask

   task automatic do_load(input int f, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'b00; req_frame = 2'(f); req_line = '0; req_data = '0;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check_eq({req, " load gives no response (R7)"}, LINE_W'(rsp_valid), '0);
   endtask

   task automatic t_reset;
      check_eq("R1 rsp_valid after reset", LINE_W'(rsp_valid), '0);
      check_eq("R1 sat_err after reset", LINE_W'(sat_err), '0);
      do_enc(2'b10, 0, 0, '0);
      check_eq("R1 unloaded frame seed is zero", LINE_W'(got_s), '0);
   endtask

   task automatic t_load_assign;
      do_load(0, "R2");
      do_load(1, "R2");
      next_id = 3;
      do_enc(2'b10, 1, 2, '0);
      check_eq("R2 R4 fill seed carries page number 2", LINE_W'(got_s), seed_of(0, 2));
      do_enc(2'b10, 0, 3, '0);
      check_eq("R2 R4 fill seed carries page number 1", LINE_W'(got_s), seed_of(0, 1));
   endtask

   task automatic t_writeback;
      logic [LINE_W-1:0] c1, c2;
      do_enc(2'b01, 1, 2, PLAIN);
      c1 = got_d;
      check_eq("R3 first writeback seed counter 1", LINE_W'(got_s), seed_of(1, 2));
      check_ne("R6 ciphertext differs from plaintext", c1, PLAIN);
      do_enc(2'b01, 1, 2, PLAIN);
      c2 = got_d;
      check_eq("R3 second writeback seed counter 2", LINE_W'(got_s), seed_of(2, 2));
      check_ne("R10 repeated writeback gives new ciphertext", c2, c1);
      do_enc(2'b10, 1, 2, c2);
      check_eq("R6 fill decrypts latest ciphertext", got_d, PLAIN);
      check_eq("R5 fill uses current counter", LINE_W'(got_s), seed_of(2, 2));
      do_enc(2'b10, 1, 2, c1);
      check_ne("R6 stale ciphertext does not decrypt", got_d, PLAIN);
      check_eq("R5 counter unchanged by fills", LINE_W'(got_s), seed_of(2, 2));
   endtask

   task automatic t_pad_relation;
      logic [LINE_W-1:0] c;
      do_enc(2'b01, 0, 1, ~PLAIN);
      c = got_d;
      do_enc(2'b10, 0, 1, '0);
      check_eq("R6 ciphertext equals plaintext xor pad", c, ~PLAIN ^ got_d);
      check_eq("R4 seed has no frame or line bits", LINE_W'(got_s), seed_of(1, 1));
   endtask

   task automatic t_reload;
      do_load(1, "R8");
      next_id = 4;
      do_enc(2'b10, 1, 2, '0);
      check_eq("R8 reload gives new page number and zero counter", LINE_W'(got_s), seed_of(0, 3));
   endtask

   task automatic t_reserved;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'b11; req_frame = 2'd1; req_line = 2'd2; req_data = PLAIN;
      @(negedge clk);
      req_valid = 1'b0;
      check_eq("R11 reserved code no response (1)", LINE_W'(rsp_valid), '0);
      @(negedge clk);
      check_eq("R11 reserved code no response (2)", LINE_W'(rsp_valid), '0);
      do_enc(2'b10, 1, 2, '0);
      check_eq("R11 reserved code leaves counter", LINE_W'(got_s), seed_of(0, 3));
   endtask

   task automatic t_back_to_back;
      logic [LINE_W-1:0] c, p;
      logic [SEED_W-1:0] s1;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'b01; req_frame = 2'd1; req_line = 2'd0; req_data = PLAIN;
      @(negedge clk);
      req_op = 2'b10; req_data = '0;
      @(negedge clk);
      req_valid = 1'b0;
      c = rsp_data; s1 = rsp_seed;
      @(negedge clk);
      p = rsp_data;
      check_eq("R12 fill response valid", LINE_W'(rsp_valid), 1);
      check_eq("R12 writeback seed", LINE_W'(s1), seed_of(1, 3));
      check_eq("R12 fill sees just-written counter", LINE_W'(rsp_seed), seed_of(1, 3));
      check_eq("R12 back-to-back pad matches", c ^ p, PLAIN);
   endtask

   task automatic t_saturate;
      while (next_id <= 14) begin
         check_eq("R9 sat_err low while ids remain", LINE_W'(sat_err), '0);
         do_load(2, "R9");
         next_id++;
      end
      check_eq("R9 sat_err raised when counter is all ones", LINE_W'(sat_err), 1);
      do_load(3, "R9");
      do_enc(2'b10, 3, 0, '0);
      check_eq("R9 refused load leaves frame unloaded", LINE_W'(got_s), seed_of(0, 0));
      do_enc(2'b10, 2, 0, '0);
      check_eq("R9 last issued page number kept", LINE_W'(got_s), seed_of(0, 14));
      check_eq("R9 sat_err stays high", LINE_W'(sat_err), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_load_assign;
      t_writeback;
      t_pad_relation;
      t_reload;
      t_reserved;
      t_back_to_back;
      t_saturate;
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchecks++;
         nerrs++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
         $finish;
      end
   end
endmodule